// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps wall-clock time and date for a chip that has a slow timebase. An external prescaler delivers `subTick`, a one-cycle pulse at 2^SUB_LOG2 Hz (256 Hz by default). The block divides that pulse down to whole seconds and advances a calendar held entirely in packed BCD: seconds, minutes, a 12-hour hour with a PM bit, weekday, day of month, month and a two-digit year. Day rollover follows month length and leap years.

Software reaches the block through a byte-wide register port. Writes take effect at the next clock edge, and reads are combinational. A run bit gates all counting. While the run bit is clear, software can load the calendar fields directly. A self-clearing initialise bit returns the calendar, the sub-second divider and the status flags to their starting values. Two sticky status flags are provided. The carry flag is set on every seconds advance. The periodic flag is set at a software-selected fraction of a second. Each flag reaches its interrupt output only when its enable bit is set.

Top module: `bcd_calendar`

## Requirements
- R1: After `rstN`, the fields read as follows: seconds 0x00, minutes 0x00, hour 0x12 (12 AM, bit 6 = PM), weekday 0, day 0x01, month 0x01 and year 0x00. Control and status read 0. Address map: 0 seconds, 1 minutes, 2 hour, 3 weekday, 4 day, 5 month, 6 year, 8 rate/enable, 9 run control, 10 status.
- R2: While the run bit (address 9, bit 0) is 0, a write to addresses 0 to 6 loads that field. The field reads back the written value, masked to its width: seconds and minutes 7 bits, hour 7 bits, weekday 3 bits, day 6 bits, month 5 bits, year 8 bits.
- R3: While the run bit is 1, writes to addresses 0 to 6 are ignored.
- R4: While the run bit is 0, `subTick` pulses change no field.
- R5: While running, seconds advance on every 2^SUB_LOG2-th `subTick`. Seconds and minutes count 00 to 59 in BCD, and a seconds wrap advances the minutes.
- R6: The hour runs 12, 01 … 11. It passes from 11 to 12 and toggles PM when the minutes wrap. Passing from 11 PM to 12 AM advances the day.
- R7: The day wraps to 01 after 28, 29, 30 or 31, according to the month and whether the binary year is divisible by 4. Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday counts 0 to 6 and advances with every day advance.
- R9: Writing 1 to address 9, bit 1 makes that bit read 1 for one cycle. The bit then reads 0, with the calendar back at its R1 values and both status flags cleared.
- R10: The carry flag (address 10, bit 1) is set on each seconds advance and stays set. Writing 0 to the bit clears it. Writing 1 has no effect.
- R11: The periodic flag (address 10, bit 2) is set every 2^(code-6) running ticks. Here code is address 8, bits 7:4, in the range 6..6+SUB_LOG2; code 0x8 gives 1/64 s. Other codes never set the flag. The flag is cleared by writing 0 to its bit.
- R12: `carryIrq` equals the carry flag gated by address 8, bit 1. `periodIrq` equals the periodic flag gated by address 8, bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| subTick | input | 1 | Prescaled sub-second pulse, one cycle wide |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Combinational read data for `regAddr` |
| carryIrq | output | 1 | Carry interrupt |
| periodIrq | output | 1 | Periodic interrupt |

## Verification
A write presented before a rising edge is visible on `regRdata` after that edge. The initialise bit reads 1 for exactly one cycle, and the cleared calendar appears one edge later. Because of this, the bench drives on falling edges and reads one cycle after each write. A seconds advance, and its carry flag, land on the edge of the 2^SUB_LOG2-th running tick counted from an initialise. The bench therefore checks that nothing has moved after one tick fewer, and that the advance has happened after the last tick. Periodic flags are checked one tick before and at their due tick. Interrupts are combinational from the flags and enables, so they are sampled in the same cycle as the flags.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int NUM_FIELDS = 7;

  localparam logic [3:0] ADDR_SEC   = 4'd0;
  localparam logic [3:0] ADDR_MIN   = 4'd1;
  localparam logic [3:0] ADDR_HOUR  = 4'd2;
  localparam logic [3:0] ADDR_WDAY  = 4'd3;
  localparam logic [3:0] ADDR_DAY   = 4'd4;
  localparam logic [3:0] ADDR_MON   = 4'd5;
  localparam logic [3:0] ADDR_YEAR  = 4'd6;
  localparam logic [3:0] ADDR_RATE  = 4'd8;
  localparam logic [3:0] ADDR_RUN   = 4'd9;
  localparam logic [3:0] ADDR_STAT  = 4'd10;

  localparam logic [6:0] INIT_HOUR = 7'h12;
  localparam logic [5:0] INIT_DAY  = 6'h01;
  localparam logic [4:0] INIT_MON  = 5'h01;

  // strobes from control to datapath
  typedef struct packed {
    logic                  step;
    logic                  init;
    logic [NUM_FIELDS-1:0] load;
    logic [7:0]            data;
  } calStrobe_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcdToBin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction
endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int         SUB_LOG2 = 8,
  parameter logic [3:0] SEL_BASE = 4'd6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             subTick,
  input  logic             regWe,
  input  logic [3:0]       regAddr,
  input  logic [7:0]       regWdata,
  output calStrobe_t       stb,
  output logic [7:0]       rateQ,
  output logic             startQ,
  output logic             resetPend,
  output logic             carryFlag,
  output logic             periodFlag
);
  localparam int NUM_RATES = SUB_LOG2 + 1;

  logic [SUB_LOG2-1:0]  subCnt;
  logic [SUB_LOG2-1:0]  subNext;
  logic [NUM_RATES-1:0] periodHit;
  logic [3:0]           selOff;
  logic                 selValid;
  logic                 hitSel;
  logic                 run, tickRun, secStep, periodEvt;
  logic                 wrCal, wrStat, wrRate, wrRun;

  assign subNext = subCnt + 1'b1;

  // one hit line per selectable rate
  for (genvar g = 0; g < NUM_RATES; g++) begin : gRate
    if (g == 0) begin : gEvery
      assign periodHit[g] = 1'b1;
    end else begin : gDiv
      assign periodHit[g] = (subNext[g-1:0] == '0);
    end
  end

  assign selOff   = rateQ[7:4] - SEL_BASE;
  assign selValid = (rateQ[7:4] >= SEL_BASE) && (int'(selOff) < NUM_RATES);

  always_comb begin
    hitSel = 1'b0;
    for (int g = 0; g < NUM_RATES; g++) begin
      if (int'(selOff) == g) hitSel = periodHit[g];
    end
  end

  assign run       = startQ & ~resetPend;
  assign tickRun   = subTick & run;
  assign secStep   = tickRun & (&subCnt);
  assign periodEvt = tickRun & selValid & hitSel;

  assign wrCal  = regWe & (regAddr < 4'd7) & ~startQ & ~resetPend;
  assign wrStat = regWe & (regAddr == ADDR_STAT);
  assign wrRate = regWe & (regAddr == ADDR_RATE);
  assign wrRun  = regWe & (regAddr == ADDR_RUN);

  always_comb begin
    stb.step = secStep;
    stb.init = resetPend;
    stb.data = regWdata;
    stb.load = wrCal ? (7'b1 << regAddr[2:0]) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateQ      <= '0;
      startQ     <= 1'b0;
      resetPend  <= 1'b0;
      subCnt     <= '0;
      carryFlag  <= 1'b0;
      periodFlag <= 1'b0;
    end else begin
      if (wrRate) rateQ <= regWdata;
      if (wrRun) begin
        startQ    <= regWdata[0];
        resetPend <= regWdata[1];
      end else if (resetPend) begin
        resetPend <= 1'b0;
      end
      if (resetPend) begin
        subCnt     <= '0;
        carryFlag  <= 1'b0;
        periodFlag <= 1'b0;
      end else begin
        if (tickRun) subCnt <= subNext;
        carryFlag  <= secStep   | (carryFlag  & ~(wrStat & ~regWdata[1]));
        periodFlag <= periodEvt | (periodFlag & ~(wrStat & ~regWdata[2]));
      end
    end
  end
endmodule

// File: rtl/cal_datapath.sv
module cal_datapath
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t stb,
  output logic [6:0] secQ,
  output logic [6:0] minQ,
  output logic [6:0] hourQ,
  output logic [2:0] wdayQ,
  output logic [5:0] dayQ,
  output logic [4:0] monQ,
  output logic [7:0] yearQ
);
  logic [7:0] secInc, minInc, hrInc, dayInc, monInc, yearInc, yearBin;
  logic       secWrap, minWrap, hrEleven, hrTwelve, leap, dayWrap, monWrap;
  logic       minStep, hrStep, dayStep, monStep, yearStep;
  logic [5:0] monthLen;
  logic [6:0] hourNext;

  always_comb begin
    secInc  = bcdInc({1'b0, secQ});
    minInc  = bcdInc({1'b0, minQ});
    hrInc   = bcdInc({2'b0, hourQ[5:0]});
    dayInc  = bcdInc({2'b0, dayQ});
    monInc  = bcdInc({3'b0, monQ});
    yearInc = bcdInc(yearQ);
    yearBin = bcdToBin(yearQ);
    leap    = (yearBin[1:0] == 2'b00);

    secWrap  = (secQ == 7'h59);
    minWrap  = (minQ == 7'h59);
    hrEleven = (hourQ[5:0] == 6'h11);
    hrTwelve = (hourQ[5:0] == 6'h12);

    unique case (monQ)
      5'h02:                      monthLen = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: monthLen = 6'h30;
      default:                    monthLen = 6'h31;
    endcase

    dayWrap = (dayQ == monthLen);
    monWrap = (monQ == 5'h12);

    minStep  = stb.step & secWrap;
    hrStep   = minStep & minWrap;
    dayStep  = hrStep & hrEleven & hourQ[6];
    monStep  = dayStep & dayWrap;
    yearStep = monStep & monWrap;

    if (hrEleven)      hourNext = {~hourQ[6], 6'h12};
    else if (hrTwelve) hourNext = {hourQ[6], 6'h01};
    else               hourNext = {hourQ[6], hrInc[5:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= '0; minQ <= '0; hourQ <= INIT_HOUR; wdayQ <= '0;
      dayQ <= INIT_DAY; monQ <= INIT_MON; yearQ <= '0;
    end else if (stb.init) begin
      secQ <= '0; minQ <= '0; hourQ <= INIT_HOUR; wdayQ <= '0;
      dayQ <= INIT_DAY; monQ <= INIT_MON; yearQ <= '0;
    end else begin
      if (stb.load[0])    secQ <= stb.data[6:0];
      else if (stb.step)  secQ <= secWrap ? 7'h00 : secInc[6:0];
      if (stb.load[1])    minQ <= stb.data[6:0];
      else if (minStep)   minQ <= minWrap ? 7'h00 : minInc[6:0];
      if (stb.load[2])    hourQ <= stb.data[6:0];
      else if (hrStep)    hourQ <= hourNext;
      if (stb.load[3])    wdayQ <= stb.data[2:0];
      else if (dayStep)   wdayQ <= (wdayQ == 3'd6) ? 3'd0 : wdayQ + 3'd1;
      if (stb.load[4])    dayQ <= stb.data[5:0];
      else if (dayStep)   dayQ <= dayWrap ? INIT_DAY : dayInc[5:0];
      if (stb.load[5])    monQ <= stb.data[4:0];
      else if (monStep)   monQ <= monWrap ? INIT_MON : monInc[4:0];
      if (stb.load[6])    yearQ <= stb.data;
      else if (yearStep)  yearQ <= (yearQ == 8'h99) ? 8'h00 : yearInc;
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int SUB_LOG2 = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       subTick,
  input  logic       regWe,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata,
  output logic       carryIrq,
  output logic       periodIrq
);
  calStrobe_t stb;
  logic [7:0] rateQ;
  logic       startQ, resetPend, carryFlag, periodFlag;
  logic [6:0] secQ, minQ, hourQ;
  logic [2:0] wdayQ;
  logic [5:0] dayQ;
  logic [4:0] monQ;
  logic [7:0] yearQ;

  cal_ctrl #(.SUB_LOG2(SUB_LOG2)) u_ctrl (
    .clk, .rstN, .subTick, .regWe, .regAddr, .regWdata,
    .stb, .rateQ, .startQ, .resetPend, .carryFlag, .periodFlag
  );

  cal_datapath u_dp (
    .clk, .rstN, .stb,
    .secQ, .minQ, .hourQ, .wdayQ, .dayQ, .monQ, .yearQ
  );

  assign carryIrq  = carryFlag & rateQ[1];
  assign periodIrq = periodFlag & rateQ[2];

  always_comb begin
    unique case (regAddr)
      ADDR_SEC:  regRdata = {1'b0, secQ};
      ADDR_MIN:  regRdata = {1'b0, minQ};
      ADDR_HOUR: regRdata = {1'b0, hourQ};
      ADDR_WDAY: regRdata = {5'b0, wdayQ};
      ADDR_DAY:  regRdata = {2'b0, dayQ};
      ADDR_MON:  regRdata = {3'b0, monQ};
      ADDR_YEAR: regRdata = yearQ;
      ADDR_RATE: regRdata = rateQ;
      ADDR_RUN:  regRdata = {6'b0, resetPend, startQ};
      ADDR_STAT: regRdata = {5'b0, periodFlag, carryFlag, 1'b0};
      default:   regRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/cal_checker.sv
module cal_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWe,
  input logic       startQ,
  input logic       resetPend,
  input logic [6:0] secQ,
  input logic [6:0] hourQ,
  input logic [2:0] wdayQ,
  input logic       carryFlag,
  input logic       periodFlag,
  input logic       carryIrq,
  input logic       periodIrq
);
  assert_bcd_seconds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!startQ) || (secQ[3:0] <= 4'd9 && secQ[6:4] <= 3'd5));

  assert_hour_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!startQ) || (hourQ[5:0] inside {6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06,
                                     6'h07, 6'h08, 6'h09, 6'h10, 6'h11, 6'h12}));

  assert_weekday_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!startQ) || (wdayQ <= 3'd6));

  assert_frozen_when_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!startQ && !resetPend && !regWe) |=> $stable(secQ));

  assert_reset_selfclear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (resetPend && !regWe) |=> (!resetPend && secQ == 7'h00 && !carryFlag));

  assert_carry_with_second_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carryFlag) |-> !$stable(secQ));

  assert_carry_irq_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    carryIrq |-> carryFlag);

  assert_period_irq_gated_R12: assert property (@(posedge clk) disable iff (!rstN)
    periodIrq |-> periodFlag);
endmodule

bind bcd_calendar cal_checker u_chk (.*);

// File: tb/sim_bcd_calendar.sv
module sim_bcd_calendar;
  localparam int TICKS = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       subTick = 1'b0;
  logic       regWe = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       carryIrq, periodIrq;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  // model state
  int mS, mM, mH, mPm, mW, mD, mMo, mY;

  always #10 clk = ~clk;

  bcd_calendar u0 (
    .clk, .rstN, .subTick, .regWe, .regAddr, .regWdata,
    .regRdata, .carryIrq, .periodIrq
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic modelStep();
    mS++;
    if (mS == 60) begin
      mS = 0; mM++;
      if (mM == 60) begin
        mM = 0;
        if (mH == 11) begin
          mH = 12; mPm = 1 - mPm;
          if (mPm == 0) begin
            mW = (mW + 1) % 7; mD++;
            if (mD > dim(mMo, mY)) begin
              mD = 1; mMo++;
              if (mMo == 13) begin mMo = 1; mY = (mY + 1) % 100; end
            end
          end
        end else if (mH == 12) mH = 1;
        else mH++;
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    subTick = 1'b1;
    repeat (n) @(negedge clk);
    subTick = 1'b0;
  endtask

  task automatic softReset();
    wr(4'd9, 8'h02);
    @(negedge clk);
  endtask

  task automatic loadModel();
    wr(4'd0, bcd(mS));
    wr(4'd1, bcd(mM));
    wr(4'd2, bcd(mH) | (mPm != 0 ? 8'h40 : 8'h00));
    wr(4'd3, 8'(mW));
    wr(4'd4, bcd(mD));
    wr(4'd5, bcd(mMo));
    wr(4'd6, bcd(mY));
  endtask

  task automatic checkFields(input string tag);
    logic [7:0] d;
    rd(4'd0, d); chk({tag, " sec"}, d, bcd(mS));
    rd(4'd1, d); chk({tag, " min"}, d, bcd(mM));
    rd(4'd2, d); chk({tag, " hour"}, d, bcd(mH) | (mPm != 0 ? 8'h40 : 8'h00));
    rd(4'd3, d); chk({tag, " wday"}, d, 8'(mW));
    rd(4'd4, d); chk({tag, " day"}, d, bcd(mD));
    rd(4'd5, d); chk({tag, " month"}, d, bcd(mMo));
    rd(4'd6, d); chk({tag, " year"}, d, bcd(mY));
  endtask

  // load model value, run exactly one second, compare
  task automatic oneSecond(input string tag);
    logic [7:0] d;
    softReset();
    loadModel();
    wr(4'd9, 8'h01);
    tick(TICKS - 1);
    rd(4'd0, d); chk({tag, " R5 no advance before last tick"}, d, bcd(mS));
    tick(1);
    wr(4'd9, 8'h00);
    modelStep();
    checkFields(tag);
  endtask

  task automatic setModel(input int s, m, h, pm, w, dd, mo, y);
    mS = s; mM = m; mH = h; mPm = pm; mW = w; mD = dd; mMo = mo; mY = y;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240614));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset values
    setModel(0, 0, 12, 0, 0, 1, 1, 0);
    checkFields("R1");
    rd(4'd9, d);  chk("R1 run ctrl", d, 8'h00);
    rd(4'd10, d); chk("R1 status", d, 8'h00);
    rd(4'd8, d);  chk("R1 rate", d, 8'h00);

    // R4 ticks while stopped
    tick(300);
    checkFields("R4 stopped");
    rd(4'd10, d); chk("R4 no carry while stopped", d, 8'h00);

    // R2 load while stopped, with masking
    setModel(30, 45, 10, 1, 3, 17, 8, 42);
    loadModel();
    checkFields("R2");
    wr(4'd3, 8'hFD);
    rd(4'd3, d); chk("R2 wday masked to 3 bits", d, 8'h05);
    wr(4'd3, 8'h03);

    // R3 writes ignored while running
    wr(4'd9, 8'h01);
    wr(4'd0, 8'h07);
    wr(4'd6, 8'h11);
    rd(4'd0, d); chk("R3 sec write ignored", d, 8'h30);
    rd(4'd6, d); chk("R3 year write ignored", d, 8'h42);
    wr(4'd9, 8'h00);

    // R9 self-clearing initialise
    wr(4'd9, 8'h02);
    rd(4'd9, d); chk("R9 reset bit visible", d, 8'h02);
    @(negedge clk);
    rd(4'd9, d); chk("R9 reset bit cleared", d, 8'h00);
    setModel(0, 0, 12, 0, 0, 1, 1, 0);
    checkFields("R9");

    // R10 and R12 carry flag
    softReset();
    wr(4'd8, 8'h02);
    wr(4'd9, 8'h01);
    tick(TICKS - 1);
    rd(4'd10, d); chk("R10 carry not yet", d & 8'h02, 8'h00);
    tick(1);
    wr(4'd9, 8'h00);
    rd(4'd10, d); chk("R10 carry set", d & 8'h02, 8'h02);
    chk("R12 carryIrq enabled", carryIrq, 1'b1);
    wr(4'd8, 8'h00);
    #1 chk("R12 carryIrq masked", carryIrq, 1'b0);
    wr(4'd10, 8'hFF);
    rd(4'd10, d); chk("R10 write one keeps", d & 8'h02, 8'h02);
    wr(4'd10, 8'hFD);
    rd(4'd10, d); chk("R10 write zero clears", d & 8'h02, 8'h00);

    // R11 periodic flag at code 0x8
    softReset();
    wr(4'd8, 8'h84);
    wr(4'd9, 8'h01);
    tick(3);
    rd(4'd10, d); chk("R11 period before 4 ticks", d & 8'h04, 8'h00);
    chk("R12 periodIrq low", periodIrq, 1'b0);
    tick(1);
    rd(4'd10, d); chk("R11 period at 4 ticks", d & 8'h04, 8'h04);
    chk("R12 periodIrq high", periodIrq, 1'b1);
    wr(4'd10, 8'hFB);
    rd(4'd10, d); chk("R11 period cleared", d & 8'h04, 8'h00);
    tick(3);
    rd(4'd10, d); chk("R11 period quiet", d & 8'h04, 8'h00);
    tick(1);
    rd(4'd10, d); chk("R11 period again", d & 8'h04, 8'h04);
    wr(4'd9, 8'h00);

    // R11 invalid code, then code 0x6
    softReset();
    wr(4'd8, 8'hF4);
    wr(4'd9, 8'h01);
    tick(520);
    rd(4'd10, d); chk("R11 invalid code silent", d & 8'h04, 8'h00);
    wr(4'd8, 8'h64);
    tick(1);
    rd(4'd10, d); chk("R11 every-tick code", d & 8'h04, 8'h04);
    wr(4'd9, 8'h00);
    wr(4'd8, 8'h00);

    // directed calendar corners
    setModel(59, 59, 11, 0, 2, 5, 3, 10);  oneSecond("R6 11AM to 12PM");
    setModel(59, 59, 12, 1, 2, 5, 3, 10);  oneSecond("R6 12PM to 1PM");
    setModel(59, 59, 12, 0, 2, 5, 3, 10);  oneSecond("R6 12AM to 1AM");
    setModel(59, 59, 11, 1, 6, 28, 2, 24); oneSecond("R7 R8 leap Feb 28");
    setModel(59, 59, 11, 1, 0, 29, 2, 24); oneSecond("R7 leap Feb 29");
    setModel(59, 59, 11, 1, 1, 28, 2, 23); oneSecond("R7 common Feb 28");
    setModel(59, 59, 11, 1, 4, 30, 4, 50); oneSecond("R7 April 30");
    setModel(59, 59, 11, 1, 5, 30, 5, 50); oneSecond("R7 May 30");
    setModel(59, 59, 11, 1, 3, 31, 12, 99); oneSecond("R7 year wrap");
    setModel(59, 9, 4, 0, 1, 12, 7, 7);    oneSecond("R5 minute BCD digit");
    setModel(9, 20, 4, 0, 1, 12, 7, 7);    oneSecond("R5 second BCD digit");

    // constrained random vectors
    for (int i = 0; i < 30; i++) begin
      int y, mo;
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      setModel(($urandom % 3 == 0) ? int'($urandom % 60) : 59,
               ($urandom % 3 == 0) ? int'($urandom % 60) : 59,
               ($urandom % 2 == 0) ? 11 : 1 + int'($urandom % 12),
               int'($urandom % 2),
               int'($urandom % 7),
               ($urandom % 2 == 0) ? dim(mo, y) : 1 + int'($urandom % 28),
               mo, y);
      oneSecond("R5 R6 R7 R8 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule